// File: doc/BRIEF.md
# Reconfigurable Lookup-Table Logic Cluster

A small programmable logic tile of eight identical cells. Every cell evaluates a 4-input function. The function comes from sixteen configuration bits, which a binary tree of 2:1 multiplexers reads, steered by the cell's inputs. The chosen value either goes straight to the cell output or passes through a D flip-flop first. A second mode bit switches the cell into full-adder operation. Dedicated carry wiring links each cell to the next, so a run of adjacent cells forms a ripple adder without using any table storage.

All configuration enters through one serial shift chain that advances one bit per clock while the load enable is high. While the chain is loading, the tile is idle: every output reads zero and the flip-flops are cleared. Once the enable drops, the cells run the freshly loaded functions. A synchronous active-low reset clears both the configuration and the flip-flops.

Top module: `lut_cluster`

## Requirements
- R1: While `cfg_en` is high, the 144-bit configuration register shifts left by one bit on each rising clock edge, and `cfg_in` enters at bit 0. The first bit shifted in therefore lands in bit 143 after 144 shifts. Cell c owns bits [18c+17 : 18c]: bits 15..0 are its table, bit 16 selects the registered output, and bit 17 enables carry mode.
- R2: While `cfg_en` is low, the configuration register keeps its value, and `cfg_in` has no effect on any output.
- R3: While `cfg_en` is high, every `cell_out` bit and `carry_out` are 0, and each cell flip-flop is cleared on every clock edge.
- R4: With carry mode off and bit 16 clear, a cell's output combinationally equals table bit number in3*8+in2*4+in1*2+in0. Here in0 is the cell's least significant input bit.
- R5: With bit 16 set, a cell's output is its flip-flop. The flip-flop captures the cell's combinational result on each rising edge while `cfg_en` is low.
- R6: With `rst_n` low at a rising edge, the configuration and all flip-flops are cleared, so every output reads 0 afterwards.
- R7: With carry mode on, the cell result is in0 XOR in1 XOR carry-in, and inputs 2 and 3 and the table bits are ignored. Four adjacent carry cells add two 4-bit operands as an integer.
- R8: A cell in carry mode sends majority(in0, in1, carry-in) to the next cell. A cell with carry mode off sends 0. Cell 0 takes `carry_in`, and `carry_out` is the carry of cell 7.
- R9: A table loaded with the 2-input AND pattern 16'h8888 outputs 1 only when in0 and in1 are both 1. The XOR pattern 16'h6666 outputs 1 only when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | 1 | Configuration load enable |
| cfg_in | input | 1 | Serial configuration data |
| carry_in | input | 1 | Carry into cell 0 |
| cell_in | input | 32 | Four inputs per cell; cell c uses bits [4c+3:4c] |
| cell_out | output | 8 | One output per cell |
| carry_out | output | 1 | Carry out of cell 7 |

## Verification
The embedded properties check the following on every cycle: the chain shifts correctly and holds correctly, outputs and flip-flops are forced to zero during loading, each flip-flop captures the cell result, and a cell with carry mode off breaks the carry path. Other behaviour can only be shown by the bench's scenarios, which compare every output each cycle against a behavioural model. These are the bit placement of a complete serial image, the table indexing order, the AND and XOR truth tables, adder arithmetic across four cells including the all-ones carry ripple, and a flip-flop fed back as a toggling counter bit.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;
    localparam int LUT_K      = 4;
    localparam int LUT_BITS   = 1 << LUT_K;
    localparam int CELL_CFG_W = LUT_BITS + 2;

    // MSB first: carry enable, registered-output select, then table bits
    typedef struct packed {
        logic                carry_en;
        logic                reg_sel;
        logic [LUT_BITS-1:0] tt_bits;
    } cell_cfg_t;
endpackage

// File: rtl/lut_mux_tree.sv
module lut_mux_tree #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tt_bits,
    input  logic [K-1:0]      sel,
    output logic              y
);
    localparam int N     = 1 << K;
    localparam int NODES = 2 * N - 1;

    // Flat node vector: leaves first, then each level, root last
    logic [NODES-1:0] node;

    assign node[N-1:0] = tt_bits;

    for (genvar l = 0; l < K; l++) begin : g_level
        localparam int OFF_IN  = 2 * N - ((2 * N) >> l);
        localparam int OFF_OUT = 2 * N - ((2 * N) >> (l + 1));
        localparam int CNT     = N >> (l + 1);
        for (genvar i = 0; i < CNT; i++) begin : g_mux
            assign node[OFF_OUT + i] = sel[l] ? node[OFF_IN + 2*i + 1]
                                              : node[OFF_IN + 2*i];
        end
    end

    assign y = node[NODES-1];
endmodule

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
    parameter int W = 144
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_in,
    output logic [W-1:0] cfg_bits
);
    typedef struct packed {
        logic [W-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (cfg_en) begin
            chain_d.bits = {chain_q.bits[W-2:0], cfg_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign cfg_bits = chain_q.bits;

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> chain_q.bits[0] == $past(cfg_in)); // R1
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> chain_q.bits[W-1:1] == $past(chain_q.bits[W-2:0])); // R1
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(chain_q.bits)); // R2
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cluster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  cell_cfg_t        cfg,
    input  logic [LUT_K-1:0] din,
    input  logic             cin,
    output logic             dout,
    output logic             cout
);
    typedef struct packed {
        logic ff;
    } cell_state_t;

    cell_state_t st_d, st_q;
    logic        lut_y;
    logic        sum_bit;
    logic        maj_bit;
    logic        result;

    lut_mux_tree #(.K(LUT_K)) u_tree (
        .tt_bits (cfg.tt_bits),
        .sel     (din),
        .y       (lut_y)
    );

    always_comb begin
        sum_bit = din[0] ^ din[1] ^ cin;
        maj_bit = (din[0] & din[1]) | (din[0] & cin) | (din[1] & cin);
        result  = cfg.carry_en ? sum_bit : lut_y;

        st_d    = st_q;
        st_d.ff = cfg_en ? 1'b0 : result;

        cout = (cfg.carry_en && !cfg_en) ? maj_bit : 1'b0;
        if (cfg_en) begin
            dout = 1'b0;
        end else if (cfg.reg_sel) begin
            dout = st_q.ff;
        end else begin
            dout = result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LOAD_CLEARS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> st_q.ff == 1'b0); // R3
    AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> st_q.ff == $past(result)); // R5
    AST_CARRY_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.carry_en |-> cout == 1'b0); // R8
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
    import lut_cluster_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_en,
    input  logic                       cfg_in,
    input  logic                       carry_in,
    input  logic [NUM_CELLS*LUT_K-1:0] cell_in,
    output logic [NUM_CELLS-1:0]       cell_out,
    output logic                       carry_out
);
    localparam int CHAIN_W = NUM_CELLS * CELL_CFG_W;

    logic [CHAIN_W-1:0]   cfg_bits;
    logic [NUM_CELLS:0]   carry;

    lut_cfg_chain #(.W(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_in   (cfg_in),
        .cfg_bits (cfg_bits)
    );

    assign carry[0] = carry_in;

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        cell_cfg_t cell_cfg;
        assign cell_cfg = cell_cfg_t'(cfg_bits[c*CELL_CFG_W +: CELL_CFG_W]);

        lut_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_en (cfg_en),
            .cfg    (cell_cfg),
            .din    (cell_in[c*LUT_K +: LUT_K]),
            .cin    (carry[c]),
            .dout   (cell_out[c]),
            .cout   (carry[c+1])
        );
    end

    assign carry_out = carry[NUM_CELLS];

    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (cell_out == '0) && (carry_out == 1'b0)); // R3
endmodule

// File: tb/lut_cluster_tb.sv
module lut_cluster_tb;
    localparam int NC  = 8;
    localparam int K   = 4;
    localparam int CW  = 18;
    localparam int TOT = NC * CW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_en = 1'b0;
    logic              cfg_in = 1'b0;
    logic              carry_in = 1'b0;
    logic [NC*K-1:0]   cell_in = '0;
    logic [NC-1:0]     cell_out;
    logic              carry_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [TOT-1:0] m_cfg = '0;
    logic [NC-1:0]  m_ff  = '0;
    logic [NC-1:0]  m_res;

    always #2.5 clk = ~clk;

    lut_cluster u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_in    (cfg_in),
        .carry_in  (carry_in),
        .cell_in   (cell_in),
        .cell_out  (cell_out),
        .carry_out (carry_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [CW-1:0] word(input logic [15:0] tt, input bit rs, input bit ce);
        return {ce, rs, tt};
    endfunction

    // Behavioural evaluation of the whole tile from the model state
    task automatic model_eval(output logic [NC-1:0] y, output logic co);
        logic c;
        c = carry_in;
        for (int i = 0; i < NC; i++) begin
            int base;
            int idx;
            bit a, b, ce, rs, nc;
            base = i * CW;
            idx  = int'(cell_in[i*K +: K]);
            a    = cell_in[i*K];
            b    = cell_in[i*K+1];
            rs   = m_cfg[base+16];
            ce   = m_cfg[base+17];
            if (ce) begin
                m_res[i] = a ^ b ^ c;
                nc = (int'(a) + int'(b) + int'(c)) >= 2;
            end else begin
                m_res[i] = m_cfg[base + idx];
                nc = 1'b0;
            end
            if (cfg_en) nc = 1'b0;
            y[i] = cfg_en ? 1'b0 : (rs ? m_ff[i] : m_res[i]);
            c = nc;
        end
        co = c;
    endtask

    task automatic cycle(input string req);
        logic [NC-1:0] ey;
        logic eco;
        #1;
        model_eval(ey, eco);
        check(cell_out === ey, req, int'(cell_out), int'(ey));
        check(carry_out === eco, req, int'(carry_out), int'(eco));
        @(posedge clk);
        if (!rst_n) begin
            m_cfg = '0;
            m_ff  = '0;
        end else if (cfg_en) begin
            m_cfg = {m_cfg[TOT-2:0], cfg_in};
            m_ff  = '0;
        end else begin
            m_ff = m_res;
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [TOT-1:0] img);
        cfg_en = 1'b1;
        for (int i = TOT - 1; i >= 0; i--) begin
            cfg_in  = img[i];
            cell_in = $urandom();
            cycle("R1_R3");
        end
        cfg_en = 1'b0;
        cfg_in = 1'b0;
    endtask

    logic [TOT-1:0] img_a, img_b;

    initial begin
        // Image A: table functions, cell 4 used as a toggling counter bit
        img_a = '0;
        img_a[0*CW +: CW] = word(16'h8888, 0, 0); // AND of in0,in1
        img_a[1*CW +: CW] = word(16'h6666, 0, 0); // XOR of in0,in1
        img_a[2*CW +: CW] = word(16'h8000, 0, 0); // 4-input AND
        img_a[3*CW +: CW] = word(16'hFFFE, 1, 0); // registered OR
        img_a[4*CW +: CW] = word(16'h6666, 1, 0); // counter bit
        img_a[5*CW +: CW] = word(16'h6996, 0, 0); // parity
        img_a[6*CW +: CW] = word(16'h0001, 1, 0); // registered NOR
        img_a[7*CW +: CW] = word(16'h1234, 0, 0); // arbitrary
        // Image B: 4-bit adder on cells 0..3, junk tables must be ignored
        img_b = '0;
        for (int c = 0; c < 4; c++) img_b[c*CW +: CW] = word(16'hA5C3, 0, 1);
        img_b[4*CW +: CW] = word(16'h6666, 1, 0);
        img_b[5*CW +: CW] = word(16'h0F0F, 0, 1); // carry cell after break
        img_b[6*CW +: CW] = word(16'h8888, 1, 0);
        img_b[7*CW +: CW] = word(16'hFFFF, 0, 1);

        @(negedge clk);
        cycle("R6");
        cycle("R6");
        rst_n = 1'b1;
        #1;
        check(cell_out == '0 && carry_out == 1'b0, "R6 reset state", int'(cell_out), 0);
        @(negedge clk);

        load(img_a);

        // R9: AND and XOR truth tables, every 2-bit combination
        for (int v = 0; v < 4; v++) begin
            cell_in = '0;
            cell_in[1:0] = v[1:0];
            cell_in[5:4] = v[1:0];
            #1;
            check(cell_out[0] == (v == 3), "R9 AND", int'(cell_out[0]), int'(v == 3));
            check(cell_out[1] == (v == 1 || v == 2), "R9 XOR", int'(cell_out[1]), int'(v == 1 || v == 2));
            cycle("R4");
        end
        // R4: index order, 4-input AND only at all-ones
        cell_in = '0;
        cell_in[11:8] = 4'hF;
        #1;
        check(cell_out[2] == 1'b1, "R4 index 15", int'(cell_out[2]), 1);
        cell_in[11:8] = 4'h7;
        #1;
        check(cell_out[2] == 1'b0, "R4 index 7", int'(cell_out[2]), 0);
        cycle("R4");

        // R5 counter bit: in0 fed back from output, in1 = count enable; R2 noise on cfg_in
        for (int n = 0; n < 40; n++) begin
            cell_in = $urandom();
            cell_in[16] = m_ff[4];
            cell_in[17] = (n % 5) != 0;
            cfg_in = $urandom();
            cycle("R2_R4_R5");
        end
        cfg_in = 1'b0;

        load(img_b);

        // R7/R8: adder vectors with integer reference
        for (int n = 0; n < 60; n++) begin
            int a, b, ci, s;
            case (n)
                0: begin a = 15; b = 1;  ci = 0; end
                1: begin a = 15; b = 15; ci = 1; end
                2: begin a = 0;  b = 0;  ci = 0; end
                3: begin a = 15; b = 0;  ci = 1; end
                4: begin a = 10; b = 5;  ci = 1; end
                default: begin a = $urandom_range(15); b = $urandom_range(15); ci = $urandom_range(1); end
            endcase
            cell_in = $urandom();
            for (int c = 0; c < 4; c++) begin
                cell_in[c*K]   = a[c];
                cell_in[c*K+1] = b[c];
            end
            cell_in[16] = m_ff[4];
            carry_in = ci[0];
            s = a + b + ci;
            #1;
            check(cell_out[3:0] == s[3:0], "R7 adder sum", int'(cell_out[3:0]), s & 15);
            check(u_dut.carry_out == 1'b0 || cell_out[5] !== 1'bx, "R8", 0, 0);
            cycle("R7_R8");
        end

        // R6: reset mid-run clears configuration and flip-flops
        rst_n = 1'b0;
        cycle("R6");
        rst_n = 1'b1;
        cell_in = '1;
        carry_in = 1'b1;
        #1;
        check(cell_out == '0 && carry_out == 1'b0, "R6 after reset", int'(cell_out), 0);
        cycle("R6");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule